// File: doc/BRIEF.md
# Program-Space Window Mapper

This block sits on the data-space side of a processor with a 16-bit data address bus and a program memory that is 24 bits wide. Any data-space access in the lower half of the address range goes straight to data RAM. A read in the upper half (address bit 15 set) goes into program memory instead. The block builds the program address from an 8-bit page register and the low data-address bits, fetches the instruction word, and returns its low 16 bits as data. Each page covers a window of 16K instruction words in the user half of program space.

The request side is a valid/ready channel. A request is taken in any cycle where `req_valid` and `req_ready` are both high. The requester must hold its request, unchanged, while `req_ready` is low. The only time `req_ready` drops is the single cycle after a window read is taken. The response side has no back-pressure. The consumer must accept `rsp_valid`/`rsp_data` in the cycle they appear. Responses come back in request order, one for each read.

The page register is loaded through a plain write strobe. A write to the upper half is not forwarded anywhere, and it is reported with a one-cycle error pulse.

Top module: `psv_window`

## Requirements
- R1: A taken request with address bit 15 clear drives `dm_en` in the same cycle, with `dm_addr` equal to the request address, `dm_we` equal to `req_write` and `dm_wdata` equal to `req_wdata`. A read of this kind raises `rsp_valid` one cycle later, with `rsp_data` equal to `dm_rdata` unchanged.
- R2: A window read drives `pm_addr` = {page, req_addr[14:1], 0}. This is 23 bits with bit 0 always zero.
- R3: A page write in cycle n applies to requests taken from cycle n+1 onward. A request taken in cycle n still uses the previous page.
- R4: A word window read returns `pm_rdata[15:0]`. Bits 23:16 of the instruction word never reach `rsp_data`.
- R5: A byte window read (`req_byte`=1) returns {8'h00, pm_rdata[7:0]} when req_addr[0]=0, and {8'h00, pm_rdata[15:8]} when req_addr[0]=1.
- R6: For a window read taken in cycle n, `pm_rd_en` is high in cycle n+1 and `rsp_valid` is high in cycle n+2. This is one cycle more than a direct read.
- R7: `req_ready` is low in exactly the cycle after a window read is taken, and high in every other cycle.
- R8: A write with address bit 15 set drives neither `dm_en` nor `pm_rd_en` and produces no response. It raises `err` for exactly the following cycle.
- R9: `rsp_valid` and `err` are never high together, and responses come back in request order.
- R10: After reset, `req_ready`=1, `rsp_valid`=0, `err`=0 and `pm_rd_en`=0, and the page register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Data-space byte address |
| req_wdata | input | 16 | Write data |
| page_we | input | 1 | Load page register |
| page_wdata | input | 8 | New page value |
| dm_en | output | 1 | Data RAM access strobe |
| dm_we | output | 1 | Data RAM write enable |
| dm_addr | output | 16 | Data RAM address |
| dm_wdata | output | 16 | Data RAM write data |
| dm_rdata | input | 16 | Data RAM read data (one cycle after `dm_en`) |
| pm_rd_en | output | 1 | Program memory read strobe |
| pm_addr | output | 23 | Program memory address |
| pm_rdata | input | 24 | Program memory word (one cycle after `pm_rd_en`) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 16 | Read data |
| err | output | 1 | One-cycle pulse for a write into the window |

## Verification
The bench targets four corner cases:

- **Page timing.** It writes the page register in the same cycle as a window read, then issues another read in the next cycle. A design that forwarded the new page too early, or latched it too late, would put the wrong high bits on `pm_addr`.
- **Word format.** It uses a program-memory model whose upper byte differs from its lower bytes, and issues word reads at odd addresses. These catch a design that leaked bits 23:16 or failed to force address bit 0 to zero.
- **Byte reads.** It issues byte reads to both lanes. A design with swapped lanes, or with sign extension instead of zero extension, would return the wrong value.
- **Timing and ordering.** It runs back-to-back mixes of window reads, direct reads and window writes. These catch a stall that lasts the wrong number of cycles, a response in the wrong cycle, or an error pulse that is missing or sent downstream as a real write.

// File: rtl/psv_pkg.sv
package psv_pkg;

  typedef enum logic [2:0] {
    ACC_NONE      = 3'd0,
    ACC_DIRECT_RD = 3'd1,
    ACC_DIRECT_WR = 3'd2,
    ACC_WINDOW_RD = 3'd3,
    ACC_WINDOW_WR = 3'd4
  } acc_kind_e;

endpackage

// File: rtl/psv_page_reg.sv
module psv_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] page
);

  always_ff @(posedge clk) begin
    if (!rst_n)  page <= '0;
    else if (we) page <= wdata;
  end

endmodule

// File: rtl/psv_classify.sv
module psv_classify
  import psv_pkg::*;
(
  input  logic      req_valid,
  input  logic      req_ready,
  input  logic      req_write,
  input  logic      addr_msb,
  output acc_kind_e kind
);

  always_comb begin
    kind = ACC_NONE;
    if (req_valid && req_ready) begin
      unique case ({addr_msb, req_write})
        2'b00:   kind = ACC_DIRECT_RD;
        2'b01:   kind = ACC_DIRECT_WR;
        2'b10:   kind = ACC_WINDOW_RD;
        default: kind = ACC_WINDOW_WR;
      endcase
    end
  end

endmodule

// File: rtl/psv_addr_fold.sv
module psv_addr_fold #(
  parameter int AW     = 16,
  parameter int PAGE_W = 8,
  localparam int OFFS_W = AW - 1,
  localparam int PM_AW  = PAGE_W + OFFS_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [OFFS_W-1:1] offset_hi,
  output logic [PM_AW-1:0]  pm_addr
);

  // Program addresses are even: bit 0 is forced low.
  assign pm_addr = {page, offset_hi, 1'b0};

endmodule

// File: rtl/psv_lane_sel.sv
module psv_lane_sel #(
  parameter int DW = 16,
  localparam int LANE_W = DW / 2
) (
  input  logic [DW-1:0] word,
  input  logic          byte_mode,
  input  logic          hi_lane,
  output logic [DW-1:0] data
);

  logic [LANE_W-1:0] lane;

  generate
    if (DW == 2 * LANE_W) begin : g_even
      assign lane = hi_lane ? word[DW-1:LANE_W] : word[LANE_W-1:0];
    end else begin : g_odd
      assign lane = word[LANE_W-1:0];
    end
  endgenerate

  assign data = byte_mode ? {{(DW-LANE_W){1'b0}}, lane} : word;

endmodule

// File: rtl/psv_window.sv
module psv_window
  import psv_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int PAGE_W = 8,
  parameter int PM_DW  = 24,
  localparam int OFFS_W = AW - 1,
  localparam int PM_AW  = PAGE_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_wdata,
  output logic              dm_en,
  output logic              dm_we,
  output logic [AW-1:0]     dm_addr,
  output logic [DW-1:0]     dm_wdata,
  input  logic [DW-1:0]     dm_rdata,
  output logic              pm_rd_en,
  output logic [PM_AW-1:0]  pm_addr,
  input  logic [PM_DW-1:0]  pm_rdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              err
);

  logic [PAGE_W-1:0] page;
  acc_kind_e         kind;
  logic [PM_AW-1:0]  folded;
  logic [DW-1:0]     lane_data;
  logic              unused_pm_hi;

  // Fetch stage of a window read
  logic              s1_q;
  logic [PM_AW-1:0]  s1_addr_q;
  logic              s1_byte_q;
  logic              s1_lane_q;
  // Return stage
  logic              s2_map_q;
  logic              s2_dir_q;
  logic              s2_byte_q;
  logic              s2_lane_q;
  logic              err_q;

  psv_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (page_we),
    .wdata (page_wdata),
    .page  (page)
  );

  psv_classify u_cls (
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .addr_msb  (req_addr[AW-1]),
    .kind      (kind)
  );

  psv_addr_fold #(.AW(AW), .PAGE_W(PAGE_W)) u_fold (
    .page      (page),
    .offset_hi (req_addr[OFFS_W-1:1]),
    .pm_addr   (folded)
  );

  psv_lane_sel #(.DW(DW)) u_lane (
    .word      (pm_rdata[DW-1:0]),
    .byte_mode (s2_byte_q),
    .hi_lane   (s2_lane_q),
    .data      (lane_data)
  );

  // Upper instruction bits are deliberately unreachable through the window.
  assign unused_pm_hi = ^pm_rdata[PM_DW-1:DW];

  // One stall cycle while the window read is being fetched.
  assign req_ready = !s1_q;

  assign dm_en    = (kind == ACC_DIRECT_RD) || (kind == ACC_DIRECT_WR);
  assign dm_we    = (kind == ACC_DIRECT_WR);
  assign dm_addr  = req_addr;
  assign dm_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q      <= 1'b0;
      s1_addr_q <= '0;
      s1_byte_q <= 1'b0;
      s1_lane_q <= 1'b0;
      s2_map_q  <= 1'b0;
      s2_dir_q  <= 1'b0;
      s2_byte_q <= 1'b0;
      s2_lane_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      s1_q     <= (kind == ACC_WINDOW_RD);
      s2_map_q <= s1_q;
      s2_dir_q <= (kind == ACC_DIRECT_RD);
      err_q    <= (kind == ACC_WINDOW_WR);
      if (kind == ACC_WINDOW_RD) begin
        s1_addr_q <= folded;
        s1_byte_q <= req_byte;
        s1_lane_q <= req_addr[0];
      end
      s2_byte_q <= s1_byte_q;
      s2_lane_q <= s1_lane_q;
    end
  end

  assign pm_rd_en  = s1_q;
  assign pm_addr   = s1_addr_q;
  assign rsp_valid = s2_map_q || s2_dir_q;
  assign rsp_data  = s2_map_q ? lane_data : dm_rdata;
  assign err       = err_q;

endmodule

// File: rtl/psv_window_chk.sv
module psv_window_chk #(
  parameter int AW     = 16,
  parameter int PM_AW  = 23,
  localparam int OFFS_W = AW - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic             dm_en,
  input logic [AW-1:0]    dm_addr,
  input logic             pm_rd_en,
  input logic [PM_AW-1:0] pm_addr,
  input logic             rsp_valid,
  input logic             err
);

  logic take, win_rd, win_wr, dir_rd;
  assign take   = req_valid && req_ready;
  assign win_rd = take && req_addr[AW-1] && !req_write;
  assign win_wr = take && req_addr[AW-1] && req_write;
  assign dir_rd = take && !req_addr[AW-1] && !req_write;

  a_r1_direct_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rd |=> rsp_valid);
  a_r1_dm_addr: assert property (@(posedge clk) disable iff (!rst_n)
    dm_en |-> (dm_addr == req_addr));
  a_r2_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd_en |-> !pm_addr[0]);
  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd |=> (pm_addr[OFFS_W-1:1] == $past(req_addr[OFFS_W-1:1])));
  a_r6_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd |=> pm_rd_en);
  a_r6_rsp_late: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd |=> ##1 rsp_valid);
  a_r7_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd |=> !req_ready);
  a_r7_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr |=> (err && !pm_rd_en && !rsp_valid));
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(win_wr));
  a_r8_no_dm: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[AW-1]) |-> !dm_en);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, err}));

endmodule

bind psv_window psv_window_chk #(.AW(AW), .PM_AW(PM_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .dm_en     (dm_en),
  .dm_addr   (dm_addr),
  .pm_rd_en  (pm_rd_en),
  .pm_addr   (pm_addr),
  .rsp_valid (rsp_valid),
  .err       (err)
);

// File: tb/psv_window_tb.sv
`timescale 1ns/1ps
module psv_window_tb;

  localparam int K_NONE = 0, K_DRD = 1, K_DWR = 2, K_MRD = 3, K_MWR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        page_we = 1'b0;
  logic [7:0]  page_wdata = '0;
  logic        req_ready, dm_en, dm_we, pm_rd_en, rsp_valid, err;
  logic [15:0] dm_addr, dm_wdata, rsp_data;
  logic [15:0] dm_rdata = '0;
  logic [22:0] pm_addr;
  logic [23:0] pm_rdata = '0;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 0;

  // bench view of the block state
  logic [7:0]  page_m = 8'h00;
  int          p1_k = K_NONE, p2_k = K_NONE;
  logic [15:0] p1_a = '0, p2_a = '0;
  logic        p1_b = 0, p2_b = 0;
  logic [22:0] p1_pm = '0, p2_pm = '0;

  always #2.5 clk = ~clk;

  psv_window u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
    .req_wdata(req_wdata), .page_we(page_we), .page_wdata(page_wdata),
    .dm_en(dm_en), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_rdata(dm_rdata), .pm_rd_en(pm_rd_en), .pm_addr(pm_addr),
    .pm_rdata(pm_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err(err)
  );

  function automatic logic [15:0] dm_fn(logic [15:0] a);
    return a ^ 16'h6C39;
  endfunction

  function automatic logic [23:0] pm_fn(logic [22:0] a);
    return {8'hE7 ^ a[7:0], a[15:0] ^ {a[22:15], 8'h3C}};
  endfunction

  function automatic logic [15:0] fmt(logic [23:0] w, logic byt, logic lane);
    if (!byt) return w[15:0];
    return lane ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  // memory models: one-cycle read latency
  always @(posedge clk) begin
    if (dm_en && !dm_we) dm_rdata <= dm_fn(dm_addr);
    if (pm_rd_en) pm_rdata <= pm_fn(pm_addr);
    else          pm_rdata <= 24'hC0FFEE;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic [15:0] ed;
    chk(req_ready == (p1_k != K_MRD), "R7 ready", 32'(req_ready), 32'(p1_k != K_MRD));
    chk(pm_rd_en == (p1_k == K_MRD), "R6 fetch strobe", 32'(pm_rd_en), 32'(p1_k == K_MRD));
    if (p1_k == K_MRD)
      chk(pm_addr == p1_pm, "R2/R3 program address", 32'(pm_addr), 32'(p1_pm));
    chk(err == (p1_k == K_MWR), "R8 error pulse", 32'(err), 32'(p1_k == K_MWR));
    chk(rsp_valid == (p1_k == K_DRD || p2_k == K_MRD), "R6/R9 rsp_valid",
        32'(rsp_valid), 32'(p1_k == K_DRD || p2_k == K_MRD));
    if (p2_k == K_MRD) begin
      ed = fmt(pm_fn(p2_pm), p2_b, p2_a[0]);
      chk(rsp_data == ed, p2_b ? "R5 byte data" : "R4 word data", 32'(rsp_data), 32'(ed));
    end else if (p1_k == K_DRD) begin
      ed = dm_fn(p1_a);
      chk(rsp_data == ed, "R1 direct data", 32'(rsp_data), 32'(ed));
    end
  endtask

  task automatic step(input logic v, input logic wr, input logic byt,
                      input logic [15:0] a, input logic [15:0] wd,
                      input logic pwe, input logic [7:0] pd, output logic acc);
    int k;
    @(negedge clk);
    check_outputs();
    req_valid = v; req_write = wr; req_byte = byt; req_addr = a; req_wdata = wd;
    page_we = pwe; page_wdata = pd;
    #1;
    acc = v && req_ready;
    k = !acc ? K_NONE : (a[15] ? (wr ? K_MWR : K_MRD) : (wr ? K_DWR : K_DRD));
    chk(dm_en == (k == K_DRD || k == K_DWR), "R1/R8 dm_en", 32'(dm_en),
        32'(k == K_DRD || k == K_DWR));
    if (k == K_DRD || k == K_DWR) begin
      chk(dm_addr == a && dm_we == wr && dm_wdata == wd, "R1 pass-through",
          {dm_we, dm_addr}, {wr, a});
    end
    p2_k = (p1_k == K_MRD) ? p1_k : K_NONE;
    p2_a = p1_a; p2_b = p1_b; p2_pm = p1_pm;
    p1_k = k; p1_a = a; p1_b = byt; p1_pm = {page_m, a[14:1], 1'b0};
    if (pwe) page_m = pd;
  endtask

  task automatic send(input logic wr, input logic byt, input logic [15:0] a,
                      input logic pwe, input logic [7:0] pd);
    logic acc;
    step(1, wr, byt, a, 16'h5AA5, pwe, pd, acc);
    while (!acc) step(1, wr, byt, a, 16'h5AA5, 0, 8'h00, acc);
  endtask

  task automatic idle(input int n);
    logic acc;
    for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0, 16'h0, 0, 8'h00, acc);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic acc;
    logic hold_v, hold_w, hold_b;
    logic [15:0] hold_a;
    void'($urandom(32'h1234_5678));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10: reset state, checked at the first step
    chk(req_ready && !rsp_valid && !err && !pm_rd_en, "R10 reset state",
        {28'h0, req_ready, rsp_valid, err, pm_rd_en}, 32'h8);
    send(0, 0, 16'h8000, 0, 8'h00);             // R10 page 0 after reset
    idle(2);
    send(0, 0, 16'h9234, 1, 8'h3A);             // R3 same-cycle page write: old page
    send(0, 0, 16'hC10A, 0, 8'h00);             // R3 new page from next cycle
    send(0, 1, 16'h8454, 0, 8'h00);             // R5 low lane
    send(0, 1, 16'h8455, 0, 8'h00);             // R5 high lane
    send(0, 0, 16'h1234, 0, 8'h00);             // R1 direct read
    send(0, 1, 16'h7FFF, 0, 8'h00);             // R1 direct byte read
    send(1, 0, 16'h0200, 0, 8'h00);             // R1 direct write
    send(1, 0, 16'hA000, 0, 8'h00);             // R8 window write ignored
    send(0, 0, 16'h8000, 0, 8'h00);             // R9 read right after error
    send(0, 0, 16'hFFFF, 1, 8'hFF);             // R2 odd word address, top
    send(0, 0, 16'hFFFF, 0, 8'h00);             // R2/R4 page FF
    send(0, 0, 16'h8002, 0, 8'h00);             // R7 back-to-back window reads
    send(0, 0, 16'h8004, 0, 8'h00);
    idle(3);
    // random mix, request held while stalled
    hold_v = 0; hold_w = 0; hold_b = 0; hold_a = '0;
    for (int i = 0; i < 5000; i++) begin
      logic pwe;
      logic [7:0] pd;
      if (!hold_v) begin
        hold_v = ($urandom_range(0, 9) < 8);
        hold_w = ($urandom_range(0, 99) < 15);
        hold_b = ($urandom_range(0, 99) < 30);
        hold_a = 16'($urandom);
      end
      pwe = ($urandom_range(0, 9) == 0);
      pd  = 8'($urandom);
      step(hold_v, hold_w, hold_b, hold_a, 16'($urandom), pwe, pd, acc);
      if (acc || !hold_v) hold_v = 0;
    end
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule